// File: doc/BRIEF.md
# Configurable ready/busy and completion-interrupt status pin

This block drives one status pin from the state of a flash write engine. After reset the pin is a level ready/busy indicator. It is low while the engine is running an operation. It is high when the engine is idle, and also when the engine has paused an operation.

A configuration write carries an 8-bit code and switches the pin into an interrupt style of use. Two bits of the code act independently. One arms a low-going pulse of fixed length each time an erase finishes. The other arms the same pulse each time a program finishes. While either bit is set the pin rests high and ignores the busy state. Writing a code whose two low bits are zero returns the pin to level mode.

The chosen mode stays in force until the next configuration write or until the reset pin is driven low. The reset is asserted asynchronously and released through a two-stage synchronizer. Command decoding and the write engine itself sit outside the block.

Top module: `sts_ready_irq`

## Requirements
- R1: While reset is active, and after it is released with no configuration write, the pin is in level mode with both event enables clear.
- R2: In level mode (code bits [1:0] both 0) the pin equals NOT(eng_busy AND NOT eng_susp): low while running, high when idle or suspended. Completion strobes have no effect on it.
- R3: When code bit 0 is 1, an erase_done strobe sampled at a clock edge drives the pin low for exactly PULSE_LEN cycles, starting right after that edge. The pin is then high again. An erase_done is ignored when bit 0 is 0.
- R4: When code bit 1 is 1, a prog_done strobe produces the same PULSE_LEN-cycle low pulse. A prog_done is ignored when bit 1 is 0.
- R5: A configuration write with code 0x00 returns the pin to level mode.
- R6: Code bits [7:2] have no effect: for example, 0xFC behaves as 0x00 and 0xFD behaves as 0x01.
- R7: An enabled completion event that arrives while a pulse is active restarts the pulse, which then lasts PULSE_LEN cycles from the new event.
- R8: A configuration write takes effect at the clock edge that samples it. An event sampled at that same edge is judged by the previous configuration. A pulse already in progress keeps its full length when the code changes from one pulse mode to another.
- R9: The configuration holds across any number of cycles without a configuration write. Driving the reset pin low returns the pin to level mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin; asserted asynchronously, released synchronously |
| eng_busy | input | 1 | Write engine is running an operation |
| eng_susp | input | 1 | Write engine has paused its operation |
| prog_done | input | 1 | One-cycle strobe: a program operation completed |
| erase_done | input | 1 | One-cycle strobe: an erase operation completed |
| cfg_we | input | 1 | One-cycle strobe: load cfg_code |
| cfg_code | input | 8 | Configuration code; bit 0 enables the erase pulse, bit 1 enables the program pulse |
| sts_pin | output | 1 | Status pin level |

## Verification
The assertions assume that completion strobes and configuration writes are sampled only on clock edges and are stable around them. They also assume that nothing about this block's inputs is known during the cycles before the synchronized reset releases. The stimulus drives every input on the falling clock edge, so values are settled well before the rising edge that samples them. It moves the reset pin only on that same edge. Random traffic keeps configuration writes rare, so each pulse mode lasts long enough to show full pulses. It also places strobes densely enough that pulses are restarted and that strobes collide with configuration writes.

// File: rtl/sts_pkg.sv
package sts_pkg;
  // Event enables taken from the two low bits of a configuration code
  typedef struct packed {
    logic prog_en;   // code bit 1
    logic erase_en;  // code bit 0
  } sts_cfg_t;

  function automatic logic cfg_is_level(input sts_cfg_t c);
    return !(c.prog_en || c.erase_en);
  endfunction
endpackage

// File: rtl/sts_rst_sync.sv
module sts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sts_cfg_reg.sv
module sts_cfg_reg
  import sts_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_we,
  input  logic [1:0] code_lo,
  output sts_cfg_t cfg
);
  sts_cfg_t cfg_q;
  sts_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.erase_en = code_lo[0];
      cfg_d.prog_en  = code_lo[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R8
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg == $past(code_lo)));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg));
endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
  parameter int PULSE_LEN = 4,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = fire || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (fire)               cnt_d = CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == CNT_W'(PULSE_LEN)));

  // R3
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && active) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sts_ready_irq.sv
module sts_ready_irq
  import sts_pkg::*;
#(
  parameter int PULSE_LEN = 4,
  parameter int CODE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_busy,
  input  logic              eng_susp,
  input  logic              prog_done,
  input  logic              erase_done,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_code,
  output logic              sts_pin
);
  logic     int_rst_n;
  sts_cfg_t cfg;
  logic     fire;
  logic     pulse_on;
  logic     level_mode;
  logic     unused_code_hi;

  // R6: only the two low code bits reach the configuration register
  assign unused_code_hi = ^cfg_code[CODE_W-1:2];

  sts_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(int_rst_n)
  );

  sts_cfg_reg u_cfg (
    .clk(clk), .rst_n(int_rst_n), .cfg_we(cfg_we),
    .code_lo(cfg_code[1:0]), .cfg(cfg)
  );

  always_comb begin
    fire = (cfg.erase_en && erase_done) || (cfg.prog_en && prog_done);
  end

  sts_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_tmr (
    .clk(clk), .rst_n(int_rst_n), .fire(fire), .active(pulse_on)
  );

  always_comb begin
    level_mode = cfg_is_level(cfg);
    if (level_mode) sts_pin = !(eng_busy && !eng_susp);
    else            sts_pin = !pulse_on;
  end

  // R3
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!int_rst_n)
    (!level_mode && $past(!level_mode) && $fell(sts_pin)) |-> $past(fire));
endmodule

// File: tb/tb_sts_ready_irq.sv
module tb_sts_ready_irq;
  localparam int LEN = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, eng_busy, eng_susp, prog_done, erase_done, cfg_we;
  logic [7:0] cfg_code;
  logic sts_pin;

  sts_ready_irq #(.PULSE_LEN(LEN), .CODE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_susp(eng_susp),
    .prog_done(prog_done), .erase_done(erase_done), .cfg_we(cfg_we),
    .cfg_code(cfg_code), .sts_pin(sts_pin)
  );

  int errs = 0;
  int checks = 0;
  string tag = "R1";

  // reference model state
  logic [1:0] m_en;
  int         m_cnt;
  logic [1:0] m_sync;

  function automatic logic exp_pin();
    if (m_en == 2'b00) return !(eng_busy && !eng_susp);
    return (m_cnt == 0);
  endfunction

  task automatic model_edge();
    logic trig;
    if (!rst_n) begin
      m_sync = 2'b00; m_en = 2'b00; m_cnt = 0;
    end else begin
      if (m_sync[1]) begin
        trig = (m_en[0] && erase_done) || (m_en[1] && prog_done);
        if (trig)           m_cnt = LEN;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        if (cfg_we)         m_en = cfg_code[1:0];
      end
      m_sync = {m_sync[0], 1'b1};
    end
  endtask

  task automatic cyc(input logic b, input logic s, input logic pd,
                     input logic ed, input logic we, input logic [7:0] code);
    logic e;
    @(negedge clk);
    e = exp_pin();
    checks++;
    if (sts_pin !== e) begin
      errs++;
      $display("FAIL %s t=%0t sts_pin actual=%b expected=%b", tag, $time, sts_pin, e);
    end
    eng_busy = b; eng_susp = s; prog_done = pd; erase_done = ed;
    cfg_we = we; cfg_code = code;
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(input int n, input logic b);
    for (int i = 0; i < n; i++) cyc(b, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_sync = 2'b00; m_en = 2'b00; m_cnt = 0;
    idle(2, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; eng_busy = 1'b1; eng_susp = 1'b0; prog_done = 1'b0;
    erase_done = 1'b0; cfg_we = 1'b0; cfg_code = 8'h00;
    m_sync = 2'b00; m_en = 2'b00; m_cnt = 0;

    // R1: reset state is level mode
    tag = "R1";
    idle(2, 1'b1);
    do_reset();
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);

    // R2: level mode follows busy/suspend, strobes ignored
    tag = "R2";
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(3, 1'b1);
    idle(2, 1'b0);

    // R3: erase pulse, program ignored
    tag = "R3";
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(LEN + 2, 1'b1);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    idle(LEN + 1, 1'b1);

    // R4: program pulse, erase ignored
    tag = "R4";
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h02);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    idle(LEN + 2, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(LEN + 1, 1'b1);

    // R6: upper code bits ignored
    tag = "R6";
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFC);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    idle(3, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFD);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(LEN + 2, 1'b1);

    // R5: code 0x00 returns to level mode
    tag = "R5";
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(2, 1'b1);
    idle(2, 1'b0);

    // R7: retrigger restarts the pulse
    tag = "R7";
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h03);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(2, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    idle(LEN + 2, 1'b0);

    // R8: same-edge event judged by old config; pulse survives mode change
    tag = "R8";
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01);
    idle(2, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h02);
    idle(LEN + 1, 1'b1);

    // R9: configuration holds, reset returns to level mode
    tag = "R9";
    idle(40, 1'b1);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    idle(LEN + 1, 1'b1);
    do_reset();
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    idle(3, 1'b1);

    // random traffic covering R2 R3 R4 R6 R7 R8
    tag = "R2_R3_R4_R7_rand";
    for (int i = 0; i < 4000; i++) begin
      logic we;
      we = ($urandom % 40) == 0;
      cyc(1'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 7 == 0),
          1'($urandom % 7 == 0), we, 8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule